// File: doc/BRIEF.md
# Hardware Spinlock Register Unit

A bank of single-bit mutex flags that several bus requesters (for example application cores and a companion controller) share through a plain word-addressed register interface. The read itself is the acquire attempt: reading a lock register tests the flag and sets it in the same cycle. The returned value says whether the caller now owns the lock (0) or must retry (1). Writing zero to a lock register frees it.

A read-only status word mirrors the flags of locks 0 to 31, whatever the bank size. Lock registers are placed one per 32-bit word starting at byte offset 0x100, and the status word is at byte offset 0x10. Every port presents one request per cycle (select, write flag, byte address, write data). Read data appears on the port's read bus in the cycle after the request. When several ports hit the same lock in one cycle, releases take effect first and then reads are granted in ascending port order.

Top module: `hwlock_bank`

## Requirements
- R1: Lock i (0 <= i < NUM_LOCKS, NUM_LOCKS one of 32, 64, 128, 256) sits at byte address 0x100 + 4*i. A word-aligned address from 0x100 + 4*NUM_LOCKS upward addresses no lock.
- R2: A read of a free lock returns 0x00000000 and leaves that lock taken.
- R3: A read of a taken lock returns 0x00000001 and the lock stays taken.
- R4: A write of 0x00000000 to a lock register frees that lock.
- R5: A write of any nonzero value to a lock register changes no lock.
- R6: A read at byte address 0x10 returns a word whose bit i is 1 when lock i (i < 32) is taken at the start of that cycle. Locks 32 and above never affect this word.
- R7: A read of any other address returns 0. This includes addresses that are not word-aligned, addresses below 0x100 other than 0x10, and addresses past the last lock. A write to such an address changes no lock.
- R8: When several ports read the same free lock in one cycle, the lowest-numbered port gets 0 and every other port gets 1.
- R9: A release write and a read of the same lock in one cycle are ordered release first, so the reader gets 0 and holds the lock.
- R10: Reset frees every lock, and read data is 0 while reset is held.
- R11: Read data of a port is registered and is valid in the cycle after its request. Bits 31:1 of a lock read are zero, and the read bus is 0 after any cycle in which the port made no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | NUM_PORTS | Per-port request valid |
| bus_wr | input | NUM_PORTS | Per-port write (1) or read (0) |
| bus_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p at bits [p*ADDR_W +: ADDR_W] |
| bus_wdata | input | NUM_PORTS*32 | Per-port write data, port p at bits [p*32 +: 32] |
| bus_rdata | output | NUM_PORTS*32 | Per-port read data, valid the cycle after the request |

## Verification
The bench runs a 64-lock, two-port instance. It sweeps every lock with single-port reads, so free and taken results are told apart per address. Nonzero and zero writes are also applied across the whole bank, which separates an ignored write from a real release. Contention on every lock uses two patterns: both ports reading the same lock at once, which shows the priority order, and a release on one port with a read on the other, which shows that the release is applied first. Selective releases of even and odd locks, with locks above 31 kept taken, show which bit positions the status word covers. Misaligned, below-base and past-end addresses show that the decode boundaries are exact.

// File: rtl/hwlock_pkg.sv
`timescale 1ns/1ps
package hwlock_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned STATUS_OFF  = 'h010;
    localparam int unsigned LOCK_BASE   = 'h100;
    localparam int unsigned STATUS_BITS = 32;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_STATUS   = 2'd1,
        ACC_LOCK     = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/hwlock_decode.sv
`timescale 1ns/1ps
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] offset;
    logic              aligned;
    logic              in_lock_range;

    assign offset        = addr - ADDR_W'(LOCK_BASE);
    assign aligned       = (addr[1:0] == 2'b00);
    assign in_lock_range = (addr >= ADDR_W'(LOCK_BASE)) &&
                           (offset[ADDR_W-1:2] < (ADDR_W-2)'(NUM_LOCKS));
    assign idx           = offset[IDX_W+1:2];

    always_comb begin
        if (!sel) begin
            kind = ACC_NONE;
        end else if (aligned && in_lock_range) begin
            kind = ACC_LOCK;
        end else if (addr == ADDR_W'(STATUS_OFF)) begin
            kind = ACC_STATUS;
        end else begin
            kind = ACC_UNMAPPED;
        end
    end
endmodule

// File: rtl/hwlock_resolve.sv
`timescale 1ns/1ps
module hwlock_resolve
    import hwlock_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned NUM_PORTS = 2,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic [NUM_LOCKS-1:0] locks_q,
    input  acc_kind_e            kind    [NUM_PORTS],
    input  logic [IDX_W-1:0]     idx     [NUM_PORTS],
    input  logic [NUM_PORTS-1:0] rd,
    input  logic [NUM_PORTS-1:0] wr_zero,
    output logic [NUM_LOCKS-1:0] locks_d,
    output logic [NUM_PORTS-1:0] busy
);
    logic [NUM_LOCKS-1:0] release_mask;
    logic [NUM_LOCKS-1:0] work;

    always_comb begin
        release_mask = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (kind[p] == ACC_LOCK && wr_zero[p]) begin
                release_mask[idx[p]] = 1'b1;
            end
        end

        work = locks_q & ~release_mask;
        busy = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (kind[p] == ACC_LOCK && rd[p]) begin
                busy[p]      = work[idx[p]];
                work[idx[p]] = 1'b1;
            end
        end
        locks_d = work;
    end
endmodule

// File: rtl/hwlock_bank.sv
`timescale 1ns/1ps
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS),
    localparam int unsigned RD_W     = NUM_PORTS * WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        bus_sel,
    input  logic [NUM_PORTS-1:0]        bus_wr,
    input  logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
    input  logic [NUM_PORTS*WORD_W-1:0] bus_wdata,
    output logic [NUM_PORTS*WORD_W-1:0] bus_rdata
);
    typedef struct packed {
        logic [NUM_LOCKS-1:0] locks;
        logic [RD_W-1:0]      rdata;
    } state_t;

    state_t state_d, state_q;

    acc_kind_e            kind [NUM_PORTS];
    logic [IDX_W-1:0]     idx  [NUM_PORTS];
    logic [NUM_PORTS-1:0] rd;
    logic [NUM_PORTS-1:0] wr_zero;
    logic [NUM_PORTS-1:0] busy;
    logic [NUM_LOCKS-1:0] locks_next;
    logic [NUM_LOCKS-1:0] locks_q;

    assign locks_q = state_q.locks;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hwlock_decode #(
            .NUM_LOCKS (NUM_LOCKS),
            .ADDR_W    (ADDR_W)
        ) u_decode (
            .sel  (bus_sel[p]),
            .addr (bus_addr[p*ADDR_W +: ADDR_W]),
            .kind (kind[p]),
            .idx  (idx[p])
        );
        assign rd[p]      = bus_sel[p] & ~bus_wr[p];
        assign wr_zero[p] = bus_sel[p] & bus_wr[p] &
                            (bus_wdata[p*WORD_W +: WORD_W] == '0);
    end

    hwlock_resolve #(
        .NUM_LOCKS (NUM_LOCKS),
        .NUM_PORTS (NUM_PORTS)
    ) u_resolve (
        .locks_q (state_q.locks),
        .kind    (kind),
        .idx     (idx),
        .rd      (rd),
        .wr_zero (wr_zero),
        .locks_d (locks_next),
        .busy    (busy)
    );

    always_comb begin
        state_d       = state_q;
        state_d.locks = locks_next;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            state_d.rdata[p*WORD_W +: WORD_W] = '0;
            if (rd[p]) begin
                case (kind[p])
                    ACC_STATUS: state_d.rdata[p*WORD_W +: WORD_W] =
                                    state_q.locks[STATUS_BITS-1:0];
                    ACC_LOCK:   state_d.rdata[p*WORD_W +: WORD_W] =
                                    {{(WORD_W-1){1'b0}}, busy[p]};
                    default:    state_d.rdata[p*WORD_W +: WORD_W] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
endmodule

// File: rtl/hwlock_bank_checker.sv
`timescale 1ns/1ps
module hwlock_bank_checker #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS-1:0]        bus_sel,
    input logic [NUM_PORTS-1:0]        bus_wr,
    input logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
    input logic [NUM_PORTS*32-1:0]     bus_wdata,
    input logic [NUM_PORTS*32-1:0]     bus_rdata,
    input logic [NUM_LOCKS-1:0]        locks_q
);
    function automatic logic hits_lock(logic [ADDR_W-1:0] a);
        return (int'(a) >= 'h100) && (int'(a) < 'h100 + 4*int'(NUM_LOCKS)) &&
               (a[1:0] == 2'b00);
    endfunction

    function automatic logic [IDX_W-1:0] lock_of(logic [ADDR_W-1:0] a);
        return IDX_W'((int'(a) - 'h100) >> 2);
    endfunction

    logic [ADDR_W-1:0] a0;
    logic [31:0]       d0, r0;
    logic              rd0_lock, rd0_status, rd0_other, wr0_lock;
    logic [IDX_W-1:0]  i0;
    logic              any_wr, any_rd, others_idle;

    assign a0          = bus_addr[ADDR_W-1:0];
    assign d0          = bus_wdata[31:0];
    assign r0          = bus_rdata[31:0];
    assign i0          = lock_of(a0);
    assign rd0_lock    = bus_sel[0] && !bus_wr[0] && hits_lock(a0);
    assign rd0_status  = bus_sel[0] && !bus_wr[0] && (int'(a0) == 'h10);
    assign rd0_other   = bus_sel[0] && !bus_wr[0] && !hits_lock(a0) && (int'(a0) != 'h10);
    assign wr0_lock    = bus_sel[0] && bus_wr[0] && hits_lock(a0);
    assign any_wr      = |(bus_sel & bus_wr);
    assign any_rd      = |(bus_sel & ~bus_wr);
    assign others_idle = (bus_sel >> 1) == '0;

    assert_reset_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (locks_q == '0) && (bus_rdata == '0));

    assert_free_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_lock && !locks_q[i0] |=> (r0 == 32'h0) && locks_q[$past(i0)]);

    assert_busy_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_lock && locks_q[i0] && !any_wr |=> (r0 == 32'h1) && locks_q[$past(i0)]);

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr0_lock && (d0 == 32'h0) && !any_rd |=> !locks_q[$past(i0)]);

    assert_nonzero_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel[0] && bus_wr[0] && (d0 != 32'h0) && others_idle |=> locks_q == $past(locks_q));

    assert_status_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_status |=> r0 == $past(locks_q[31:0]));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_other |=> r0 == 32'h0);

    assert_lock_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_lock |=> r0[31:1] == 31'h0);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel[0] && !bus_wr[0]) |=> r0 == 32'h0);

    if (NUM_PORTS >= 2) begin : g_pair
        logic [ADDR_W-1:0] a1;
        logic [31:0]       r1;
        logic              rd1_lock;
        logic [IDX_W-1:0]  i1;

        assign a1       = bus_addr[2*ADDR_W-1:ADDR_W];
        assign r1       = bus_rdata[63:32];
        assign i1       = lock_of(a1);
        assign rd1_lock = bus_sel[1] && !bus_wr[1] && hits_lock(a1);

        assert_low_port_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rd0_lock && rd1_lock && (i0 == i1) && !locks_q[i0]
            |=> (r0 == 32'h0) && (r1 == 32'h1));

        assert_release_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr0_lock && (d0 == 32'h0) && rd1_lock && (i0 == i1)
            |=> (r1 == 32'h0) && locks_q[$past(i1)]);
    end
endmodule

bind hwlock_bank hwlock_bank_checker #(
    .NUM_LOCKS (NUM_LOCKS),
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .locks_q   (locks_q)
);

// File: tb/hwlock_bank_tb.sv
`timescale 1ns/1ps
module hwlock_bank_tb;
    localparam int NL = 64;
    localparam int NP = 2;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     bus_sel = '0;
    logic [NP-1:0]     bus_wr = '0;
    logic [AW-1:0]     addr_a [NP];
    logic [31:0]       wd_a   [NP];
    logic [NP*AW-1:0]  bus_addr;
    logic [NP*32-1:0]  bus_wdata;
    logic [NP*32-1:0]  bus_rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  model [NL];

    always #2.5 clk = ~clk;

    for (genvar p = 0; p < NP; p++) begin : g_flat
        assign bus_addr[p*AW +: AW]  = addr_a[p];
        assign bus_wdata[p*32 +: 32] = wd_a[p];
    end

    hwlock_bank #(.NUM_LOCKS(NL), .NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [AW-1:0] lock_addr(int i);
        return AW'(256 + 4*i);
    endfunction

    function automatic logic [31:0] rdata_of(int p);
        return bus_rdata[p*32 +: 32];
    endfunction

    function automatic logic [31:0] status_exp();
        logic [31:0] s;
        for (int i = 0; i < 32; i++) s[i] = model[i];
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(int p, bit w, logic [AW-1:0] a, logic [31:0] d);
        bus_sel[p] = 1'b1;
        bus_wr[p]  = w;
        addr_a[p]  = a;
        wd_a[p]    = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        bus_sel = '0;
        bus_wr  = '0;
    endtask

    task automatic read_status(string req);
        drive(0, 1'b0, AW'(16), 32'h0);
        tick();
        check(req, rdata_of(0), status_exp());
    endtask

    task automatic release_all();
        for (int i = 0; i < NL; i++) begin
            drive(1, 1'b1, lock_addr(i), 32'h0);
            tick();
            model[i] = 1'b0;
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            addr_a[p] = '0;
            wd_a[p]   = '0;
        end
        for (int i = 0; i < NL; i++) model[i] = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        check("R10 rdata in reset", bus_rdata[31:0], 32'h0);
        rst_n = 1'b1;
        read_status("R10 status after reset");

        // R2 / R1: take every lock once through its mapped address
        for (int i = 0; i < NL; i++) begin
            drive(0, 1'b0, lock_addr(i), 32'h0);
            tick();
            check("R2 R1 free read", rdata_of(0), 32'h0);
            model[i] = 1'b1;
        end
        read_status("R6 all taken");

        // R3: every lock now reports busy
        for (int i = 0; i < NL; i++) begin
            drive(1, 1'b0, lock_addr(i), 32'h0);
            tick();
            check("R3 R11 taken read", rdata_of(1), 32'h1);
        end

        // R11: idle cycle clears read bus
        tick();
        check("R11 idle rdata", rdata_of(1), 32'h0);

        // R5: nonzero writes ignored
        for (int i = 0; i < NL; i++) begin
            drive(0, 1'b1, lock_addr(i), 32'h1 << (i % 32));
            tick();
        end
        read_status("R5 status after nonzero writes");
        drive(0, 1'b0, lock_addr(45), 32'h0);
        tick();
        check("R5 high lock still taken", rdata_of(0), 32'h1);

        // R4: release even locks, then odd locks below 32
        for (int i = 0; i < NL; i += 2) begin
            drive(1, 1'b1, lock_addr(i), 32'h0);
            tick();
            model[i] = 1'b0;
        end
        read_status("R4 even released");
        for (int i = 1; i < 32; i += 2) begin
            drive(1, 1'b1, lock_addr(i), 32'h0);
            tick();
            model[i] = 1'b0;
        end
        read_status("R6 high locks absent from status");
        drive(0, 1'b0, lock_addr(33), 32'h0);
        tick();
        check("R6 lock 33 still taken", rdata_of(0), 32'h1);
        drive(0, 1'b0, lock_addr(34), 32'h0);
        tick();
        check("R4 released lock reacquired", rdata_of(0), 32'h0);
        model[34] = 1'b1;
        release_all();
        read_status("R4 all released");

        // R8: both ports contend on every lock
        for (int i = 0; i < NL; i++) begin
            drive(1, 1'b0, lock_addr(i), 32'h0);
            drive(0, 1'b0, lock_addr(i), 32'h0);
            tick();
            check("R8 port0 wins", rdata_of(0), 32'h0);
            check("R8 port1 loses", rdata_of(1), 32'h1);
            model[i] = 1'b1;
        end

        // R9: release on port0 and read on port1, same lock, same cycle
        for (int i = 0; i < NL; i++) begin
            drive(0, 1'b1, lock_addr(i), 32'h0);
            drive(1, 1'b0, lock_addr(i), 32'h0);
            tick();
            check("R9 reader acquires", rdata_of(1), 32'h0);
            drive(0, 1'b0, lock_addr(i), 32'h0);
            tick();
            check("R9 lock held after", rdata_of(0), 32'h1);
        end
        release_all();

        // R7 / R1: unmapped reads and writes
        drive(0, 1'b0, AW'(0), 32'h0);       tick(); check("R7 addr 0x000", rdata_of(0), 32'h0);
        drive(0, 1'b0, AW'(20), 32'h0);      tick(); check("R7 addr 0x014", rdata_of(0), 32'h0);
        drive(0, 1'b0, AW'(18), 32'h0);      tick(); check("R7 addr 0x012", rdata_of(0), 32'h0);
        drive(0, 1'b0, AW'(258), 32'h0);     tick(); check("R7 misaligned", rdata_of(0), 32'h0);
        drive(0, 1'b0, lock_addr(NL), 32'h0); tick(); check("R1 past end", rdata_of(0), 32'h0);
        drive(0, 1'b0, AW'(4092), 32'h0);    tick(); check("R7 top addr", rdata_of(0), 32'h0);
        drive(0, 1'b0, lock_addr(0), 32'h0); tick(); check("R2 take lock 0", rdata_of(0), 32'h0);
        model[0] = 1'b1;
        drive(0, 1'b1, AW'(252), 32'h0); tick();
        drive(0, 1'b1, AW'(16), 32'h0);  tick();
        drive(0, 1'b1, AW'(258), 32'h0); tick();
        drive(0, 1'b1, AW'(257), 32'h0); tick();
        read_status("R7 unmapped writes ignored");

        // R10: reset mid-run frees everything
        drive(0, 1'b0, lock_addr(40), 32'h0); tick();
        drive(0, 1'b0, lock_addr(7), 32'h0);  tick();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) model[i] = 1'b0;
        read_status("R10 status after second reset");
        drive(0, 1'b0, lock_addr(40), 32'h0); tick();
        check("R10 lock 40 free", rdata_of(0), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule